// File: doc/BRIEF.md
# TLB Invalidate Access Gate

This block decides what happens when a core issues the system instruction that drops all stage-1 TLB entries of the current virtual machine. That instruction comes in two forms: a plain form, and an XS-excluding form that only waits for accesses whose XS attribute is clear. The gate takes the decoded system-instruction fields together with a snapshot of the privilege and control state. One cycle later it reports exactly one of four outcomes: the instruction is undefined, it traps to EL2 with exception class 0x18, it retires with no effect, or it becomes an invalidate request.

For an invalidate request the gate also gives the attributes a TLB controller needs. These are the translation regime (guest EL1&0 or host EL2&0), whether the current VMID qualifies the match, the broadcast scope, and whether entries marked XS are left out of the completion wait. Encodings that belong to neither form raise no result at all. The whole priority order is handled in one decision: level checks first, then the hypervisor TLB trap, then the fine-grained trap, then forced broadcast and forced XS exclusion.

Top module: `tlb_inval_gate`

## Requirements
- R1: Only an encoding with grp=2'b01, opc1=3'b000, minor=4'b0111, opc2=3'b000 and major=4'b1000 (plain form) or 4'b1001 (XS-excluding form) produces a result. Any other encoding leaves res_valid and all outcome flags low.
- R2: A matching request sampled on one rising edge gives its result on the next rising edge. A cycle without a request gives res_valid low, with all outcome flags, res_ec and the attribute outputs at zero.
- R3: When res_valid is high, exactly one of res_undef, res_trap, res_nop and res_inval is high.
- R4: The XS-excluding form is undefined when feat_xs is low, at any level. Either form is undefined at level 0 (cur_lvl=2'd0).
- R5: At level 1 with lvl2_active high, tlb_trap high gives res_trap, with res_ec equal to 0x18. res_ec is zero for every other outcome.
- R6: At level 1 with lvl2_active high and tlb_trap low, fg_inv_trap gives a trap only when feat_fg is high and either feat_el3 is low or fg_el3_allow is high.
- R7: For the XS-excluding form, the fine-grained trap of R6 also needs feat_ext_ctl high, and it is suppressed when ext_ctl_on and fg_xs_exempt are both high.
- R8: An invalidate at level 1 has res_scope=1 (inner-shareable) exactly when lvl2_active and bcast_force are both high. Every other invalidate has res_scope=0 (non-shareable).
- R9: res_xs_skip is always 1 for the XS-excluding form. For the plain form it is 1 only at level 1, and only with feat_xs, feat_ext_ctl, ext_ctl_on and xs_force all high.
- R10: At level 2 or 3 with host_mode high, an invalidate has res_regime=1 (EL2&0) and res_vmid_use=0. Every other invalidate has res_regime=0 (EL1&0) and res_vmid_use=1. host_mode has no effect at level 1.
- R11: At level 3 with feat_realm high and sec_ok low, the result is res_nop.
- R12: While rst_n is low, every output is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A decoded system instruction is presented |
| enc_grp | input | 2 | Encoding group field |
| enc_opc1 | input | 3 | First opcode field |
| enc_major | input | 4 | Major register-number field |
| enc_minor | input | 4 | Minor register-number field |
| enc_opc2 | input | 3 | Second opcode field |
| cur_lvl | input | 2 | Current exception level, 0 to 3 |
| lvl2_active | input | 1 | EL2 is enabled for the current state |
| host_mode | input | 1 | EL2 runs as host of EL0 |
| tlb_trap | input | 1 | Hypervisor TLB-maintenance trap control |
| bcast_force | input | 1 | Hypervisor forced-broadcast control |
| feat_el3 | input | 1 | EL3 is implemented |
| fg_el3_allow | input | 1 | EL3 permits fine-grained traps |
| fg_inv_trap | input | 1 | Fine-grained trap bit for this instruction |
| ext_ctl_on | input | 1 | Extended hypervisor control register is enabled |
| xs_force | input | 1 | Force XS exclusion on the plain form |
| fg_xs_exempt | input | 1 | Exempt the XS-excluding form from fine-grained traps |
| feat_xs | input | 1 | XS attribute feature present |
| feat_fg | input | 1 | Fine-grained trap feature present |
| feat_ext_ctl | input | 1 | Extended hypervisor control feature present |
| feat_realm | input | 1 | Realm management feature present |
| sec_ok | input | 1 | Target security state is valid |
| res_valid | output | 1 | A result is presented |
| res_undef | output | 1 | Outcome: undefined |
| res_trap | output | 1 | Outcome: trap to EL2 |
| res_nop | output | 1 | Outcome: completes with no effect |
| res_inval | output | 1 | Outcome: invalidate request |
| res_ec | output | 6 | Exception class on trap, else zero |
| res_regime | output | 1 | 0 = EL1&0, 1 = EL2&0 |
| res_vmid_use | output | 1 | Match on current VMID |
| res_scope | output | 1 | 0 = non-shareable, 1 = inner-shareable |
| res_xs_skip | output | 1 | Exclude XS-marked accesses from the completion wait |

## Verification
Every decision is made fresh from one registered snapshot, so a wrong rung in the priority chain shows at the ports on the very next cycle. It appears as the wrong outcome flag, or as an invalidate carrying the wrong regime, VMID or scope attribute. A slipped register shows as a result that appears on an idle cycle, or as two flags high at once, again within one cycle. The sweep covers every combination of level, form and control bits, so a missing term in a trap condition or exemption shows up in at least one combination.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;

   typedef enum logic [1:0] {
      OC_UNDEF = 2'd0,
      OC_TRAP  = 2'd1,
      OC_NOP   = 2'd2,
      OC_INVAL = 2'd3
   } outcome_e;

   localparam logic RG_GUEST = 1'b0;
   localparam logic RG_HOST  = 1'b1;

   typedef struct packed {
      logic [1:0] lvl;
      logic       lvl2_active;
      logic       host_mode;
      logic       tlb_trap;
      logic       bcast_force;
      logic       feat_el3;
      logic       fg_el3_allow;
      logic       fg_inv_trap;
      logic       ext_ctl_on;
      logic       xs_force;
      logic       fg_xs_exempt;
      logic       feat_xs;
      logic       feat_fg;
      logic       feat_ext_ctl;
      logic       feat_realm;
      logic       sec_ok;
   } ctl_t;

   typedef struct packed {
      outcome_e kind;
      logic     regime;
      logic     vmid_use;
      logic     scope;
      logic     xs_skip;
   } dec_t;

endpackage

// File: rtl/tlbg_decode.sv
module tlbg_decode #(
   parameter int GRP_W  = 2,
   parameter int OPC1_W = 3,
   parameter int MAJ_W  = 4,
   parameter int MIN_W  = 4,
   parameter int OPC2_W = 3,
   parameter logic [GRP_W-1:0]  GRP_CODE  = 2'b01,
   parameter logic [OPC1_W-1:0] OPC1_CODE = 3'b000,
   parameter logic [MAJ_W-1:0]  MAJ_BASE  = 4'b1000,
   parameter logic [MIN_W-1:0]  MIN_CODE  = 4'b0111,
   parameter logic [OPC2_W-1:0] OPC2_CODE = 3'b000
) (
   input  logic [GRP_W-1:0]  enc_grp,
   input  logic [OPC1_W-1:0] enc_opc1,
   input  logic [MAJ_W-1:0]  enc_major,
   input  logic [MIN_W-1:0]  enc_minor,
   input  logic [OPC2_W-1:0] enc_opc2,
   output logic              hit,
   output logic              xs_var
);
   // variant 0 = plain form, variant 1 = XS-excluding form (major + 1)
   localparam int NVAR = 2;

   logic            common;
   logic [NVAR-1:0] var_hit;

   assign common = (enc_grp == GRP_CODE) && (enc_opc1 == OPC1_CODE) &&
                   (enc_minor == MIN_CODE) && (enc_opc2 == OPC2_CODE);

   for (genvar v = 0; v < NVAR; v++) begin : g_var
      localparam logic [MAJ_W-1:0] VCODE = MAJ_BASE + MAJ_W'(v);
      assign var_hit[v] = common && (enc_major == VCODE);
   end

   assign hit    = |var_hit;
   assign xs_var = var_hit[1];
endmodule

// File: rtl/tlbg_prio.sv
module tlbg_prio
   import tlbg_pkg::*;
(
   input  logic xs_var,
   input  ctl_t c,
   output dec_t d
);
   logic fg_reach;
   logic xs_forced;

   always_comb begin
      fg_reach = c.feat_fg && (!c.feat_el3 || c.fg_el3_allow) && c.fg_inv_trap;
      if (xs_var) begin
         fg_reach = fg_reach && c.feat_ext_ctl && !(c.ext_ctl_on && c.fg_xs_exempt);
      end
      xs_forced = c.feat_xs && c.feat_ext_ctl && c.ext_ctl_on && c.xs_force;
   end

   always_comb begin
      d      = '0;
      d.kind = OC_UNDEF;
      if (xs_var && !c.feat_xs) begin
         d.kind = OC_UNDEF;
      end else begin
         unique case (c.lvl)
            2'd0: d.kind = OC_UNDEF;
            2'd1: begin
               if (c.lvl2_active && c.tlb_trap) begin
                  d.kind = OC_TRAP;
               end else if (c.lvl2_active && fg_reach) begin
                  d.kind = OC_TRAP;
               end else begin
                  d.kind     = OC_INVAL;
                  d.regime   = RG_GUEST;
                  d.vmid_use = 1'b1;
                  d.scope    = c.lvl2_active && c.bcast_force;
                  d.xs_skip  = xs_var || xs_forced;
               end
            end
            default: begin
               if (c.lvl == 2'd3 && c.feat_realm && !c.sec_ok) begin
                  d.kind = OC_NOP;
               end else begin
                  d.kind     = OC_INVAL;
                  d.regime   = c.host_mode ? RG_HOST : RG_GUEST;
                  d.vmid_use = !c.host_mode;
                  d.scope    = 1'b0;
                  d.xs_skip  = xs_var;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tlbg_oreg.sv
module tlbg_oreg
   import tlbg_pkg::*;
#(
   parameter int              EC_W        = 6,
   parameter logic [EC_W-1:0] TRAP_EC     = 6'h18,
   parameter bit              STORE_FLAGS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  dec_t            in_dec,
   output logic            res_valid,
   output logic            res_undef,
   output logic            res_trap,
   output logic            res_nop,
   output logic            res_inval,
   output logic [EC_W-1:0] res_ec,
   output logic            res_regime,
   output logic            res_vmid_use,
   output logic            res_scope,
   output logic            res_xs_skip
);
   logic valid_q;
   logic regime_q, vmid_q, scope_q, xs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         regime_q <= 1'b0;
         vmid_q   <= 1'b0;
         scope_q  <= 1'b0;
         xs_q     <= 1'b0;
      end else begin
         valid_q  <= in_valid;
         regime_q <= in_valid && in_dec.regime;
         vmid_q   <= in_valid && in_dec.vmid_use;
         scope_q  <= in_valid && in_dec.scope;
         xs_q     <= in_valid && in_dec.xs_skip;
      end
   end

   if (STORE_FLAGS) begin : g_flags
      logic [3:0] flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= '0;
         end else begin
            flag_q <= {in_valid && in_dec.kind == OC_INVAL,
                       in_valid && in_dec.kind == OC_NOP,
                       in_valid && in_dec.kind == OC_TRAP,
                       in_valid && in_dec.kind == OC_UNDEF};
         end
      end
      assign res_undef = flag_q[0];
      assign res_trap  = flag_q[1];
      assign res_nop   = flag_q[2];
      assign res_inval = flag_q[3];
   end else begin : g_kind
      outcome_e kind_q;
      always_ff @(posedge clk) begin
         if (!rst_n) kind_q <= OC_UNDEF;
         else        kind_q <= in_dec.kind;
      end
      assign res_undef = valid_q && kind_q == OC_UNDEF;
      assign res_trap  = valid_q && kind_q == OC_TRAP;
      assign res_nop   = valid_q && kind_q == OC_NOP;
      assign res_inval = valid_q && kind_q == OC_INVAL;
   end

   assign res_valid    = valid_q;
   assign res_ec       = res_trap ? TRAP_EC : '0;
   assign res_regime   = regime_q;
   assign res_vmid_use = vmid_q;
   assign res_scope    = scope_q;
   assign res_xs_skip  = xs_q;
endmodule

// File: rtl/tlb_inval_gate.sv
module tlb_inval_gate
   import tlbg_pkg::*;
#(
   parameter int              GRP_W       = 2,
   parameter int              OPC1_W      = 3,
   parameter int              MAJ_W       = 4,
   parameter int              MIN_W       = 4,
   parameter int              OPC2_W      = 3,
   parameter int              EC_W        = 6,
   parameter logic [EC_W-1:0] TRAP_EC     = 6'h18,
   parameter bit              STORE_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [GRP_W-1:0]  enc_grp,
   input  logic [OPC1_W-1:0] enc_opc1,
   input  logic [MAJ_W-1:0]  enc_major,
   input  logic [MIN_W-1:0]  enc_minor,
   input  logic [OPC2_W-1:0] enc_opc2,
   input  logic [1:0]        cur_lvl,
   input  logic              lvl2_active,
   input  logic              host_mode,
   input  logic              tlb_trap,
   input  logic              bcast_force,
   input  logic              feat_el3,
   input  logic              fg_el3_allow,
   input  logic              fg_inv_trap,
   input  logic              ext_ctl_on,
   input  logic              xs_force,
   input  logic              fg_xs_exempt,
   input  logic              feat_xs,
   input  logic              feat_fg,
   input  logic              feat_ext_ctl,
   input  logic              feat_realm,
   input  logic              sec_ok,
   output logic              res_valid,
   output logic              res_undef,
   output logic              res_trap,
   output logic              res_nop,
   output logic              res_inval,
   output logic [EC_W-1:0]   res_ec,
   output logic              res_regime,
   output logic              res_vmid_use,
   output logic              res_scope,
   output logic              res_xs_skip
);
   localparam int MIN_EC_W = 5;

   if (EC_W < MIN_EC_W) begin : g_bad_ec
      $error("tlb_inval_gate: EC_W too narrow for trap class");
   end
   if (GRP_W != 2 || OPC1_W != 3 || OPC2_W != 3 || MAJ_W != 4 || MIN_W != 4) begin : g_bad_enc
      $error("tlb_inval_gate: encoding field widths must match the system-instruction layout");
   end

   logic hit, xs_var;
   ctl_t ctl;
   dec_t dec;

   tlbg_decode #(
      .GRP_W(GRP_W), .OPC1_W(OPC1_W), .MAJ_W(MAJ_W), .MIN_W(MIN_W), .OPC2_W(OPC2_W)
   ) u_decode (
      .enc_grp(enc_grp), .enc_opc1(enc_opc1), .enc_major(enc_major),
      .enc_minor(enc_minor), .enc_opc2(enc_opc2), .hit(hit), .xs_var(xs_var)
   );

   assign ctl = '{lvl: cur_lvl, lvl2_active: lvl2_active, host_mode: host_mode,
                  tlb_trap: tlb_trap, bcast_force: bcast_force, feat_el3: feat_el3,
                  fg_el3_allow: fg_el3_allow, fg_inv_trap: fg_inv_trap,
                  ext_ctl_on: ext_ctl_on, xs_force: xs_force, fg_xs_exempt: fg_xs_exempt,
                  feat_xs: feat_xs, feat_fg: feat_fg, feat_ext_ctl: feat_ext_ctl,
                  feat_realm: feat_realm, sec_ok: sec_ok};

   tlbg_prio u_prio (.xs_var(xs_var), .c(ctl), .d(dec));

   tlbg_oreg #(.EC_W(EC_W), .TRAP_EC(TRAP_EC), .STORE_FLAGS(STORE_FLAGS)) u_oreg (
      .clk(clk), .rst_n(rst_n), .in_valid(req_valid && hit), .in_dec(dec),
      .res_valid(res_valid), .res_undef(res_undef), .res_trap(res_trap),
      .res_nop(res_nop), .res_inval(res_inval), .res_ec(res_ec),
      .res_regime(res_regime), .res_vmid_use(res_vmid_use),
      .res_scope(res_scope), .res_xs_skip(res_xs_skip)
   );
endmodule

// File: rtl/tlbg_chk.sv
module tlbg_chk #(
   parameter int              EC_W    = 6,
   parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [1:0]      cur_lvl,
   input logic            lvl2_active,
   input logic            tlb_trap,
   input logic            bcast_force,
   input logic            feat_realm,
   input logic            sec_ok,
   input logic            res_valid,
   input logic            res_undef,
   input logic            res_trap,
   input logic            res_nop,
   input logic            res_inval,
   input logic [EC_W-1:0] res_ec,
   input logic            res_regime,
   input logic            res_vmid_use,
   input logic            res_scope
);
   // R3
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $countones({res_undef, res_trap, res_nop, res_inval}) == 1);

   // R2
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> !res_valid);

   // R2
   quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !(res_undef || res_trap || res_nop || res_inval));

   // R4
   lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && cur_lvl == 2'd0) |-> !(res_trap || res_nop || res_inval));

   // R5
   tlb_trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && cur_lvl == 2'd1 && lvl2_active && tlb_trap) |-> !res_inval);

   // R5
   trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_trap |-> res_ec == TRAP_EC);

   // R8
   scope_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_scope |-> $past(cur_lvl == 2'd1 && lvl2_active && bcast_force));

   // R10
   host_novmid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_inval && res_regime) |-> !res_vmid_use);

   // R11
   nop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_nop |-> $past(cur_lvl == 2'd3 && feat_realm && !sec_ok));
endmodule

bind tlb_inval_gate tlbg_chk #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
   .lvl2_active(lvl2_active), .tlb_trap(tlb_trap), .bcast_force(bcast_force),
   .feat_realm(feat_realm), .sec_ok(sec_ok), .res_valid(res_valid),
   .res_undef(res_undef), .res_trap(res_trap), .res_nop(res_nop),
   .res_inval(res_inval), .res_ec(res_ec), .res_regime(res_regime),
   .res_vmid_use(res_vmid_use), .res_scope(res_scope)
);

// File: tb/tlb_inval_gate_tb.sv
`timescale 1ns/1ps
module tlb_inval_gate_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] enc_grp = '0;
   logic [2:0] enc_opc1 = '0;
   logic [3:0] enc_major = '0;
   logic [3:0] enc_minor = '0;
   logic [2:0] enc_opc2 = '0;
   logic [1:0] cur_lvl = '0;
   logic lvl2_active = 0, host_mode = 0, tlb_trap = 0, bcast_force = 0;
   logic feat_el3 = 0, fg_el3_allow = 0, fg_inv_trap = 0, ext_ctl_on = 0;
   logic xs_force = 0, fg_xs_exempt = 0, feat_xs = 0, feat_fg = 0;
   logic feat_ext_ctl = 0, feat_realm = 0, sec_ok = 0;
   logic res_valid, res_undef, res_trap, res_nop, res_inval;
   logic [5:0] res_ec;
   logic res_regime, res_vmid_use, res_scope, res_xs_skip;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tlb_inval_gate u_dut (.*);

   wire [14:0] act_v = {res_valid, res_undef, res_trap, res_nop, res_inval, res_ec,
                        res_regime, res_vmid_use, res_scope, res_xs_skip};

   task automatic chk(input logic [14:0] act, input logic [14:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_one(input string tag);
      checks++;
      if (res_valid && $countones({res_undef, res_trap, res_nop, res_inval}) != 1) begin
         errors++;
         $display("FAIL %s actual=%b expected=one-hot", tag,
                  {res_undef, res_trap, res_nop, res_inval});
      end
   endtask

   task automatic set_enc(input logic xs);
      enc_grp = 2'b01; enc_opc1 = 3'b000; enc_major = xs ? 4'b1001 : 4'b1000;
      enc_minor = 4'b0111; enc_opc2 = 3'b000;
   endtask

   task automatic drive(input int unsigned i);
      req_valid    = 1'b1;
      set_enc(i[0]);
      cur_lvl      = i[2:1];
      lvl2_active  = i[3];
      host_mode    = i[4];
      tlb_trap     = i[5];
      bcast_force  = i[6];
      fg_el3_allow = i[7];
      fg_inv_trap  = i[8];
      ext_ctl_on   = i[9];
      xs_force     = i[10];
      fg_xs_exempt = i[11];
      feat_xs      = i[12];
      feat_fg      = i[13];
      feat_ext_ctl = i[14];
      feat_realm   = i[15];
      sec_ok       = i[16];
      feat_el3     = i[4] ^ i[6];
   endtask

   // Outcome model written from the requirements: {valid,undef,trap,nop,inval,ec,regime,vmid,scope,xs}
   function automatic logic [14:0] model(input int unsigned i, output string tag);
      logic xs; logic [1:0] lv; logic l2, hm, el3, fg, fx;
      logic u, t, n, v, rg, vm, sc, xk;
      xs = i[0]; lv = i[2:1]; l2 = i[3]; hm = i[4]; el3 = i[4] ^ i[6];
      u = 0; t = 0; n = 0; v = 0; rg = 0; vm = 0; sc = 0; xk = 0;
      fg = i[13] && (!el3 || i[7]) && i[8];
      if (xs) fg = fg && i[14] && !(i[9] && i[11]);
      fx = i[12] && i[14] && i[9] && i[10];
      if (xs && !i[12]) begin u = 1; tag = "R4 xs form without feature"; end
      else if (lv == 0) begin u = 1; tag = "R4 level 0"; end
      else if (lv == 1) begin
         if (l2 && i[5]) begin t = 1; tag = "R5 tlb trap"; end
         else if (l2 && fg) begin t = 1; tag = xs ? "R7 fine trap xs form" : "R6 fine trap"; end
         else begin
            v = 1; vm = 1; sc = l2 && i[6]; xk = xs || fx;
            tag = "R8/R9 level 1 invalidate";
            if (xs && l2 && i[8]) tag = "R7 fine trap suppressed";
            else if (l2 && i[8]) tag = "R6 fine trap not armed";
         end
      end else if (lv == 3 && i[15] && !i[16]) begin n = 1; tag = "R11 invalid state"; end
      else begin
         v = 1; rg = hm; vm = !hm; xk = xs; tag = "R10 level 2/3 invalidate";
      end
      return {1'b1, u, t, n, v, (t ? 6'h18 : 6'h00), rg, vm, sc, xk};
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [14:0] prev_exp;
      string prev_tag;
      logic have_prev;
      string t0;
      have_prev = 0;
      // R12: a matching request held during reset must not reach the outputs
      @(negedge clk);
      drive(32'h4);
      repeat (3) @(negedge clk);
      chk(act_v, 15'h0, "R12 reset state");
      rst_n = 1'b1;
      req_valid = 1'b0;
      @(negedge clk);
      chk(act_v, 15'h0, "R2 idle after reset");

      for (int i = 0; i < (1 << 17); i++) begin
         @(negedge clk);
         if (have_prev) begin
            chk(act_v, prev_exp, prev_tag);
            chk_one("R3 single outcome");
         end
         drive(i);
         prev_exp  = model(i, t0);
         prev_tag  = t0;
         have_prev = 1;
      end
      @(negedge clk);
      chk(act_v, prev_exp, prev_tag);
      req_valid = 1'b0;
      @(negedge clk);
      chk(act_v, 15'h0, "R2 no request gives quiet outputs");

      // R1: near-miss encodings at level 2 produce nothing
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (k > 0) chk(act_v, 15'h0, "R1 unmatched encoding");
         drive(32'h4);
         case (k)
            0: enc_grp   = 2'b11;
            1: enc_opc1  = 3'b001;
            2: enc_major = 4'b1010;
            3: enc_major = 4'b0000;
            4: enc_minor = 4'b0110;
            5: enc_opc2  = 3'b100;
            6: enc_major = 4'b1011;
            default: enc_grp = 2'b00;
         endcase
      end
      @(negedge clk);
      chk(act_v, 15'h0, "R1 unmatched encoding");
      // R1: matching encoding again yields a level-2 guest invalidate
      drive(32'h4);
      @(negedge clk);
      chk(act_v, {1'b1, 4'b0001, 6'h00, 4'b0100}, "R1 matched encoding");
      req_valid = 1'b0;
      @(negedge clk);
      chk(act_v, 15'h0, "R2 quiet after last request");
      finish_run();
   end
endmodule